// File: doc/BRIEF.md
# Two-Register Stack Execution Core

This block is a small byte-coded stack processor. It fetches one-byte opcodes, each followed by zero or two operand bytes, from an instruction port. It runs them against a stack whose two uppermost entries sit in registers. Entries deeper than those two live in a spill region of data memory. The spill region starts at a stack-base address that is captured at reset and grows toward lower addresses. Program data is reached only through the push and pop instructions. Arithmetic, clear, increment and branch instructions work on stack values alone.

Both memory ports are valid/ready request channels. The core raises valid with a stable address, write flag and write data, and holds them until the cycle in which ready is high. That cycle is the transfer. For a read, the memory must present read data combinationally in that same cycle. If ready stays low, the core stalls with nothing else changing, for as long as ready is low. Only one of the two ports requests at a time.

The core halts on an illegal opcode or on a stack underflow and raises a flag for the cause. Three counters measure program cost: instruction bytes fetched, data words read and data words written. The two data counters include spill and refill traffic. A program normally ends with byte 0x00, which halts the core through the illegal-opcode flag.

Top module: `stk_core`

## Requirements
- R1: While reset is low and just after, the core is not halted, all three counters are zero, both flags are clear, and it requests instruction address 0. The stack-base input is captured as the first spill address.
- R2: Opcodes are one byte. Push 0x01, pop 0x02, branch-if-zero 0x07, branch-if-nonzero 0x08 and jump 0x09 each take two further operand bytes, low byte first. The fetch counter counts every instruction byte transferred.
- R3: Push reads the data word at its operand address and puts it on top. Pop writes the top entry to its operand address and removes it. No other instruction touches program data addresses.
- R4: Add (0x03) replaces the two upper entries with their sum. Subtract (0x04) replaces them with second-from-top minus top. Both wrap modulo 2^32.
- R5: Zero (0x05) clears the top entry in place. Increment (0x06) adds one to the top entry.
- R6: Branch-if-zero pops the top entry and jumps to the absolute 16-bit operand address when that entry was zero; otherwise it continues at the next instruction. Branch-if-nonzero inverts the condition. Jump always goes to its operand and leaves the stack alone.
- R7: A push made while two or more entries are held writes the old second entry to the spill pointer address, then decrements the pointer. A removal made while more than two entries are held increments the pointer and reads the new second entry back from that address.
- R8: Any opcode outside 0x01 to 0x09 sets the illegal flag and halts the core. After that, no further memory requests are made.
- R9: Pop, zero, increment or a branch on an empty stack, or add or subtract with fewer than two entries, sets the underflow flag and halts the core. The faulting instruction makes no memory access.
- R10: The read and write counters each count every completed data-port transfer of their kind, spill and refill transfers included.
- R11: On either port, a request that is not accepted keeps valid high and keeps its address, write flag and write data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stack_base | input | 16 | First spill address, captured at reset |
| imem_valid | output | 1 | Instruction byte request |
| imem_ready | input | 1 | Instruction memory accepts the request |
| imem_addr | output | 16 | Instruction byte address |
| imem_rdata | input | 8 | Instruction byte, valid in the accepting cycle |
| dmem_valid | output | 1 | Data word request |
| dmem_ready | input | 1 | Data memory accepts the request |
| dmem_we | output | 1 | Request is a write |
| dmem_addr | output | 16 | Data word address |
| dmem_wdata | output | 32 | Write data |
| dmem_rdata | input | 32 | Read data, valid in the accepting cycle |
| halted | output | 1 | Core has stopped |
| illegal_op | output | 1 | Stopped on an undefined opcode |
| underflow | output | 1 | Stopped on a stack underflow |
| fetch_bytes | output | 32 | Instruction bytes fetched |
| data_reads | output | 32 | Data words read |
| data_writes | output | 32 | Data words written |

## Verification
The bench targets stacks that cross the two-register boundary in both directions. A core that mislocates or skips a spill leaves wrong words in the spill region and returns wrong sums after refills. It also exercises operations on empty and one-entry stacks. A core with a wrong depth check either accesses memory or keeps running when it should stop. Branches are taken and not taken around a skipped instruction, and operands above 255 are used, so a swapped operand byte order or an inverted condition changes final memory and the byte count. Ready is withheld at random on both ports, so any request that changes or drops while stalled shows up as a protocol violation or as corrupted memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OPND_W = 16;

  localparam logic [7:0] OP_PUSH = 8'h01;
  localparam logic [7:0] OP_POP  = 8'h02;
  localparam logic [7:0] OP_ADD  = 8'h03;
  localparam logic [7:0] OP_SUB  = 8'h04;
  localparam logic [7:0] OP_ZERO = 8'h05;
  localparam logic [7:0] OP_INC  = 8'h06;
  localparam logic [7:0] OP_BZ   = 8'h07;
  localparam logic [7:0] OP_BNZ  = 8'h08;
  localparam logic [7:0] OP_JMP  = 8'h09;

  typedef enum logic [3:0] {
    S_OP, S_LO, S_HI, S_EXE, S_DRD, S_DWR, S_SPILL, S_FILL, S_HALT
  } core_state_t;

  function automatic logic has_operand(input logic [7:0] op);
    return (op == OP_PUSH) || (op == OP_POP) || (op == OP_BZ) ||
           (op == OP_BNZ) || (op == OP_JMP);
  endfunction
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [7:0]    op,
  input  logic [DW-1:0] second,
  input  logic [DW-1:0] top,
  output logic [DW-1:0] result
);
  always_comb begin
    case (op)
      OP_ADD:  result = second + top;
      OP_SUB:  result = second - top;
      OP_ZERO: result = '0;
      OP_INC:  result = top + DW'(1);
      default: result = top;
    endcase
  end
endmodule

// File: rtl/stk_meter.sv
module stk_meter #(
  parameter int CW = 32,
  parameter int NCNT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCNT-1:0] evt,
  output logic [CW-1:0] count [NCNT]
);
  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count[g] <= '0;
      else if (evt[g]) count[g] <= count[g] + CW'(1);
    end
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int DEPTH_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OPND_W-1:0]    stack_base,
  output logic                 imem_valid,
  input  logic                 imem_ready,
  output logic [OPND_W-1:0]    imem_addr,
  input  logic [7:0]           imem_rdata,
  output logic                 dmem_valid,
  input  logic                 dmem_ready,
  output logic                 dmem_we,
  output logic [OPND_W-1:0]    dmem_addr,
  output logic [DW-1:0]        dmem_wdata,
  input  logic [DW-1:0]        dmem_rdata,
  output logic                 halted,
  output logic                 illegal_op,
  output logic                 underflow,
  output logic [CW-1:0]        fetch_bytes,
  output logic [CW-1:0]        data_reads,
  output logic [CW-1:0]        data_writes
);
  localparam logic [DEPTH_W-1:0] D1 = DEPTH_W'(1);
  localparam logic [DEPTH_W-1:0] D2 = DEPTH_W'(2);

  core_state_t         state;
  logic [OPND_W-1:0]   pc, opnd, sp;
  logic [7:0]          opcode;
  logic [DW-1:0]       tos, nos, spill_q, alu_res;
  logic [DEPTH_W-1:0]  depth;
  logic                ill_q, und_q;
  logic                fire_i, fire_d, taken;
  logic [CW-1:0]       cnt [3];

  assign imem_valid = (state == S_OP) || (state == S_LO) || (state == S_HI);
  assign imem_addr  = pc;
  assign dmem_valid = (state == S_DRD) || (state == S_DWR) ||
                      (state == S_SPILL) || (state == S_FILL);
  assign dmem_we    = (state == S_DWR) || (state == S_SPILL);
  assign fire_i     = imem_valid && imem_ready;
  assign fire_d     = dmem_valid && dmem_ready;
  assign halted     = (state == S_HALT);
  assign illegal_op = ill_q;
  assign underflow  = und_q;
  assign taken      = (tos == '0) ^ (opcode == OP_BNZ);

  always_comb begin
    case (state)
      S_SPILL: dmem_addr = sp;
      S_FILL:  dmem_addr = sp + OPND_W'(1);
      default: dmem_addr = opnd;
    endcase
    dmem_wdata = (state == S_SPILL) ? spill_q : tos;
  end

  stk_alu #(.DW(DW)) u_alu (
    .op(opcode), .second(nos), .top(tos), .result(alu_res)
  );

  stk_meter #(.CW(CW), .NCNT(3)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .evt({fire_d && dmem_we, fire_d && !dmem_we, fire_i}),
    .count(cnt)
  );
  assign fetch_bytes = cnt[0];
  assign data_reads  = cnt[1];
  assign data_writes = cnt[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OP;  pc <= '0;  opnd <= '0;  opcode <= '0;
      tos <= '0;  nos <= '0;  spill_q <= '0;  depth <= '0;
      sp <= stack_base;  ill_q <= 1'b0;  und_q <= 1'b0;
    end else begin
      case (state)
        S_OP: if (fire_i) begin
          opcode <= imem_rdata;
          pc     <= pc + OPND_W'(1);
          state  <= has_operand(imem_rdata) ? S_LO : S_EXE;
        end
        S_LO: if (fire_i) begin
          opnd[7:0] <= imem_rdata;
          pc        <= pc + OPND_W'(1);
          state     <= S_HI;
        end
        S_HI: if (fire_i) begin
          opnd[15:8] <= imem_rdata;
          pc         <= pc + OPND_W'(1);
          state      <= S_EXE;
        end
        S_EXE: begin
          case (opcode)
            OP_PUSH: state <= S_DRD;
            OP_POP: begin
              if (depth == '0) begin und_q <= 1'b1; state <= S_HALT; end
              else state <= S_DWR;
            end
            OP_ADD, OP_SUB: begin
              if (depth < D2) begin und_q <= 1'b1; state <= S_HALT; end
              else begin
                tos   <= alu_res;
                depth <= depth - D1;
                state <= (depth > D2) ? S_FILL : S_OP;
              end
            end
            OP_ZERO, OP_INC: begin
              if (depth == '0) begin und_q <= 1'b1; state <= S_HALT; end
              else begin tos <= alu_res; state <= S_OP; end
            end
            OP_BZ, OP_BNZ: begin
              if (depth == '0) begin und_q <= 1'b1; state <= S_HALT; end
              else begin
                if (taken) pc <= opnd;
                tos   <= nos;
                depth <= depth - D1;
                state <= (depth > D2) ? S_FILL : S_OP;
              end
            end
            OP_JMP: begin pc <= opnd; state <= S_OP; end
            default: begin ill_q <= 1'b1; state <= S_HALT; end
          endcase
        end
        S_DRD: if (fire_d) begin
          tos     <= dmem_rdata;
          nos     <= tos;
          spill_q <= nos;
          depth   <= depth + D1;
          state   <= (depth >= D2) ? S_SPILL : S_OP;
        end
        S_DWR: if (fire_d) begin
          tos   <= nos;
          depth <= depth - D1;
          state <= (depth > D2) ? S_FILL : S_OP;
        end
        S_SPILL: if (fire_d) begin
          sp    <= sp - OPND_W'(1);
          state <= S_OP;
        end
        S_FILL: if (fire_d) begin
          nos   <= dmem_rdata;
          sp    <= sp + OPND_W'(1);
          state <= S_OP;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  // R11
  imem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_valid && !imem_ready |=> imem_valid && $stable(imem_addr));

  // R11
  dmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_valid && !dmem_ready |=> dmem_valid && $stable(dmem_addr) &&
                                  $stable(dmem_we) && $stable(dmem_wdata));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !imem_valid && !dmem_valid);

  // R2
  fetch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_valid && imem_ready |=> fetch_bytes == $past(fetch_bytes) + CW'(1));

  // R10
  data_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_valid && dmem_ready) |=> $stable(data_reads) && $stable(data_writes));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_op && underflow));
endmodule

// File: tb/stk_core_tb.sv
`timescale 1ns/1ps
module stk_core_tb;
  localparam logic [7:0] T_PUSH = 8'h01, T_POP = 8'h02, T_ADD = 8'h03,
                         T_SUB = 8'h04, T_ZERO = 8'h05, T_INC = 8'h06,
                         T_BZ = 8'h07, T_BNZ = 8'h08, T_JMP = 8'h09;
  localparam int BASE = 16'h03F0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [15:0] stack_base = 16'(BASE);
  logic imem_valid, imem_ready = 1'b0, dmem_valid, dmem_ready = 1'b0, dmem_we;
  logic [15:0] imem_addr, dmem_addr;
  logic [7:0] imem_rdata;
  logic [31:0] dmem_wdata, dmem_rdata;
  logic halted, illegal_op, underflow;
  logic [31:0] fetch_bytes, data_reads, data_writes;

  logic [7:0]  imem [0:255];
  logic [31:0] dmem [0:1023];
  logic [31:0] exp_mem [0:1023];

  int tests = 0, fails = 0, plen = 0, proto_err = 0;
  int m_fb, m_rd, m_wr;
  bit m_ill, m_und;

  assign imem_rdata = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[9:0]];

  stk_core u_dut (
    .clk(clk), .rst_n(rst_n), .stack_base(stack_base),
    .imem_valid(imem_valid), .imem_ready(imem_ready), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .dmem_valid(dmem_valid), .dmem_ready(dmem_ready),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .halted(halted), .illegal_op(illegal_op),
    .underflow(underflow), .fetch_bytes(fetch_bytes), .data_reads(data_reads),
    .data_writes(data_writes)
  );

  // Behavioural data memory write and R11 protocol monitor
  logic pv_i = 1'b0, pv_d = 1'b0;
  logic [15:0] pa_i, pa_d;
  logic [31:0] pw_d;
  logic pwe_d;
  always @(posedge clk) begin
    if (rst_n) begin
      if (pv_i && (!imem_valid || imem_addr != pa_i)) proto_err++;
      if (pv_d && (!dmem_valid || dmem_addr != pa_d || dmem_we != pwe_d ||
                   (pwe_d && dmem_wdata != pw_d))) proto_err++;
      pv_i = imem_valid && !imem_ready;  pa_i = imem_addr;
      pv_d = dmem_valid && !dmem_ready;  pa_d = dmem_addr;
      pwe_d = dmem_we;  pw_d = dmem_wdata;
      if (dmem_valid && dmem_ready && dmem_we) dmem[dmem_addr[9:0]] = dmem_wdata;
    end else begin
      pv_i = 1'b0;  pv_d = 1'b0;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk);
      imem_ready = ($urandom % 4) != 0;
      dmem_ready = ($urandom % 3) != 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic emit(input logic [7:0] b);
    imem[plen[7:0]] = b;
    plen++;
  endtask
  task automatic op1(input logic [7:0] op);
    emit(op);
  endtask
  task automatic op3(input logic [7:0] op, input int a);
    emit(op); emit(a[7:0]); emit(a[15:8]);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    for (int i = 0; i < 1024; i++) dmem[i] = 32'(i * 7 + 3);
    plen = 0;
  endtask

  // Reference interpreter built from the requirements
  task automatic run_model();
    int pc = 0, d = 0, steps = 0;
    logic [31:0] stk [0:63];
    logic [7:0] op;
    logic [15:0] a;
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) exp_mem[i] = dmem[i];
    m_fb = 0; m_rd = 0; m_wr = 0; m_ill = 0; m_und = 0;
    while (steps < 2000) begin
      steps++;
      op = imem[pc[7:0]];
      a = {imem[8'(pc + 2)], imem[8'(pc + 1)]};
      if (op == T_PUSH || op == T_POP || op == T_BZ || op == T_BNZ || op == T_JMP) begin
        m_fb += 3; pc += 3;
      end else begin
        m_fb += 1; pc += 1;
      end
      case (op)
        T_PUSH: begin
          v = exp_mem[a[9:0]]; m_rd++;
          if (d >= 2) begin exp_mem[10'(BASE - (d - 2))] = stk[d - 2]; m_wr++; end
          stk[d] = v; d++;
        end
        T_POP: begin
          if (d == 0) begin m_und = 1; break; end
          exp_mem[a[9:0]] = stk[d - 1]; m_wr++;
          if (d > 2) m_rd++;
          d--;
        end
        T_ADD, T_SUB: begin
          if (d < 2) begin m_und = 1; break; end
          stk[d - 2] = (op == T_ADD) ? stk[d - 2] + stk[d - 1] : stk[d - 2] - stk[d - 1];
          if (d > 2) m_rd++;
          d--;
        end
        T_ZERO, T_INC: begin
          if (d == 0) begin m_und = 1; break; end
          stk[d - 1] = (op == T_ZERO) ? 32'd0 : stk[d - 1] + 32'd1;
        end
        T_BZ, T_BNZ: begin
          if (d == 0) begin m_und = 1; break; end
          v = stk[d - 1];
          if (d > 2) m_rd++;
          d--;
          if ((v == 0) ^ (op == T_BNZ)) pc = int'(a);
        end
        T_JMP: pc = int'(a);
        default: begin m_ill = 1; break; end
      endcase
    end
  endtask

  task automatic run_prog(input string mem_req);
    int mism = 0, wait_c = 0;
    run_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    while (!halted && wait_c < 20000) begin @(negedge clk); wait_c++; end
    repeat (10) @(negedge clk);
    chk(halted, "R8", halted, 1);
    chk(illegal_op == m_ill, "R8", illegal_op, m_ill);
    chk(underflow == m_und, "R9", underflow, m_und);
    chk(fetch_bytes == 32'(m_fb), "R2", fetch_bytes, m_fb);
    chk(data_reads == 32'(m_rd), "R10", data_reads, m_rd);
    chk(data_writes == 32'(m_wr), "R10", data_writes, m_wr);
    for (int i = 0; i < 1024; i++) if (dmem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, mem_req, mism, 0);
    chk(proto_err == 0, "R11", proto_err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state, then multiply loop (R3, R6): result = a * b
    begin_prog();
    dmem[16'h10] = 32'd5; dmem[16'h11] = 32'd3; dmem[16'h12] = 32'd0; dmem[16'h13] = 32'd0;
    op3(T_PUSH, 16'h11); op3(T_PUSH, 16'h12); op1(T_SUB); op3(T_BZ, 30);
    op3(T_PUSH, 16'h13); op3(T_PUSH, 16'h10); op1(T_ADD); op3(T_POP, 16'h13);
    op3(T_PUSH, 16'h12); op1(T_INC); op3(T_POP, 16'h12); op3(T_JMP, 0);
    op1(8'h00);
    @(negedge clk);
    chk(!halted && fetch_bytes == 0 && data_reads == 0 && data_writes == 0,
        "R1", fetch_bytes, 0);
    chk(imem_valid && imem_addr == 16'h0000 && !illegal_op && !underflow,
        "R1", imem_addr, 0);
    run_prog("R6");
    chk(dmem[16'h13] == 32'd15, "R3", dmem[16'h13], 15);

    // R4 subtract order and wrap
    begin_prog();
    dmem[16'h10] = 32'd3; dmem[16'h11] = 32'd10;
    op3(T_PUSH, 16'h10); op3(T_PUSH, 16'h11); op1(T_SUB); op3(T_POP, 16'h20);
    op1(8'h00);
    run_prog("R4");
    chk(dmem[16'h20] == 32'hFFFF_FFF9, "R4", dmem[16'h20], 32'hFFFF_FFF9);

    // R5 zero in place then increments
    begin_prog();
    op3(T_PUSH, 16'h10); op1(T_ZERO); op1(T_INC); op1(T_INC); op3(T_POP, 16'h21);
    op1(8'h00);
    run_prog("R5");
    chk(dmem[16'h21] == 32'd2, "R5", dmem[16'h21], 2);

    // R7 deep stack: spills and refills, operand address above 255 (R2)
    begin_prog();
    dmem[16'h10] = 32'd10; dmem[16'h11] = 32'd3; dmem[16'h12] = 32'd7; dmem[16'h123] = 32'd2;
    op3(T_PUSH, 16'h10); op3(T_PUSH, 16'h11); op3(T_PUSH, 16'h12); op3(T_PUSH, 16'h123);
    op1(T_ADD); op1(T_SUB); op1(T_ADD); op3(T_POP, 16'h22);
    op1(8'h00);
    run_prog("R7");
    chk(dmem[16'h22] == 32'd4, "R7", dmem[16'h22], 4);
    chk(dmem[BASE] == 32'd10 && dmem[BASE - 1] == 32'd3, "R7", dmem[BASE], 10);

    // R9 pop on empty stack, add with one entry
    begin_prog();
    op3(T_POP, 16'h10); op1(8'h00);
    run_prog("R9");
    begin_prog();
    op3(T_PUSH, 16'h10); op1(T_ADD); op3(T_POP, 16'h10); op1(8'h00);
    run_prog("R9");

    // R8 illegal opcode mid-program
    begin_prog();
    op3(T_PUSH, 16'h10); op1(8'hAB); op3(T_POP, 16'h30); op1(8'h00);
    run_prog("R8");
    chk(fetch_bytes == 32'd4, "R8", fetch_bytes, 4);

    // Random programs: R3 R4 R5 R6 R7 together
    for (int it = 0; it < 25; it++) begin
      int n;
      begin_prog();
      for (int k = 16; k < 24; k++) dmem[k] = ($urandom % 3 == 0) ? 32'd0 : $urandom % 50;
      op3(T_PUSH, 16'h10 + ($urandom % 8));
      op3(T_PUSH, 16'h10 + ($urandom % 8));
      op3(T_PUSH, 16'h10 + ($urandom % 8));
      n = 6 + $urandom % 14;
      for (int k = 0; k < n; k++) begin
        case ($urandom % 10)
          0, 1, 2: op3(T_PUSH, 16'h10 + ($urandom % 8));
          3: op3(T_POP, 16'h10 + ($urandom % 8));
          4: op1(T_ADD);
          5: op1(T_SUB);
          6: op1(T_ZERO);
          7: op1(T_INC);
          8: begin op3(T_BZ, plen + 4); op1(T_INC); end
          default: begin op3(T_BNZ, plen + 4); op1(T_INC); end
        endcase
      end
      op3(T_POP, 16'h18);
      op1(8'h00);
      run_prog("R3");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule